// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Sequencer

This block turns single requests from a synchronous valid/ready port into strobe sequences for an asynchronous dynamic memory. The memory holds 4-bit words at a 20-bit address. The address reaches the part in two halves over one shared set of pins. The row half is latched when the row strobe falls. The column half is latched when the column strobe falls. All strobes and the write enable are active low. Each phase of a cycle lasts a fixed number of clock cycles, set by a parameter.

Five cycle shapes are available: a plain read, a late write, an early write, a read-modify-write and a row-only refresh. A free-running timer raises a refresh request every `REF_PERIOD` clocks. When the current cycle ends, that request is served before any new access. Each timer refresh uses the next row from a pointer, and the pointer wraps after the last row. The port stays not-ready for the whole of every cycle. A read result comes back with a one-clock valid pulse.

Top module: `dram_seq`

## Requirements
- R1: While reset is held and just after it, the outputs are in their idle state: `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `dram_dq_oe` is low, `dram_a` and `dram_dq_out` are zero, `rsp_valid` is low and `req_ready` is high.
- R2: An accepted request runs these phases in order:
  - row setup for `T_RSU` clocks, with the strobes high and `dram_a` = `req_addr[9:0]`;
  - row-to-column delay for `T_RCD` clocks, with the row strobe low and `dram_a` still the row;
  - column setup for `T_CSU` clocks, with `dram_a` = `req_addr[19:10]` and the column strobe high;
  - the column-strobe phase;
  - precharge for `T_RP` clocks, with everything idle.
- R3: A read (`req_cmd` 0) holds the column strobe low for `T_CAS` clocks with write enable high. The data input is sampled on the last of those clocks. That data appears on `rsp_data` with `rsp_valid` high for exactly the first precharge clock.
- R4: A late write (`req_cmd` 1) keeps write enable high in the first column-strobe clock. It then drives write enable low, sets `dram_dq_oe` and puts the write nibble on `dram_dq_out` for the remaining `T_CAS-1` clocks.
- R5: An early write (`req_cmd` 2) drives write enable low and the write nibble from the first column-setup clock to the end of the column-strobe phase.
- R6: A read-modify-write (`req_cmd` 3) holds the column strobe low for `2*T_CAS` clocks. The first half reads, and the old nibble is returned with a one-clock `rsp_valid` in the first clock of the second half. The second half writes the new nibble with write enable low.
- R7: A refresh request (`req_cmd` 4) presents `req_addr[9:0]` on `dram_a` from row setup to precharge. It holds the row strobe low for `T_RCD+T_CSU+T_CAS` clocks. The column strobe and write enable stay high throughout, and no response is returned.
- R8: A refresh becomes pending every `REF_PERIOD` clocks after reset. Each timer refresh has the R7 shape on the row held by an internal pointer. The pointer starts at 0, advances by one per timer refresh and wraps to 0 after row `2^ROW_W-1`.
- R9: A pending refresh is started the first idle clock it meets, ahead of any waiting request, and `req_ready` stays low while it is pending.
- R10: `req_ready` is high only when no cycle is running and no refresh is pending. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high.
- R11: Command codes 5, 6 and 7 run a plain read exactly as code 0 does.
- R12: Between cycles `dram_a`, `dram_dq_out` and `dram_dq_oe` are zero and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_cmd | input | 3 | Cycle kind: 0 read, 1 late write, 2 early write, 3 read-modify-write, 4 refresh, 5-7 read |
| req_addr | input | 20 | Word address; bits 9:0 are the row, bits 19:10 the column |
| req_wdata | input | 4 | Nibble to write |
| rsp_valid | output | 1 | One-clock read-data strobe |
| rsp_data | output | 4 | Read nibble |
| dram_a | output | 10 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 4 | Data towards the memory |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
The bench aims at the edges of each cycle shape.

- Late write: a sequencer that drove write enable in the first strobe clock would write before the column is latched.
- Read-modify-write: if the read sample came at the wrong clock, the old nibble would be lost, because the write is already on the bus.
- Refresh against requests: a request held valid the moment the timer fires must wait. A sequencer that let it through first, or that pulsed the column strobe during refresh, shows up as a pin mismatch in that cycle.
- Row pointer: a long idle stretch takes the pointer through more than 2^10 refreshes, so a pointer that failed to wrap or skipped a row is caught.

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int ROW_W      = 10,
  parameter int COL_W      = 10,
  parameter int DW         = 4,
  parameter int T_RSU      = 1,
  parameter int T_RCD      = 2,
  parameter int T_CSU      = 1,
  parameter int T_CAS      = 3,
  parameter int T_RP       = 2,
  parameter int REF_PERIOD = 780
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic [2:0]                                req_cmd,
  input  logic [ROW_W+COL_W-1:0]                    req_addr,
  input  logic [DW-1:0]                             req_wdata,
  output logic                                      rsp_valid,
  output logic [DW-1:0]                             rsp_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
  output logic                                      dram_ras_n,
  output logic                                      dram_cas_n,
  output logic                                      dram_we_n,
  output logic [DW-1:0]                             dram_dq_out,
  output logic                                      dram_dq_oe,
  input  logic [DW-1:0]                             dram_dq_in
);

  localparam int MW   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LMAX = T_RSU + T_RCD + T_CSU + 2 * T_CAS + T_RP;
  localparam int CW   = $clog2(LMAX + 1);
  localparam int RCW  = $clog2(REF_PERIOD + 1);

  localparam logic [2:0] OP_RD  = 3'd0;
  localparam logic [2:0] OP_LW  = 3'd1;
  localparam logic [2:0] OP_EW  = 3'd2;
  localparam logic [2:0] OP_RMW = 3'd3;
  localparam logic [2:0] OP_REF = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_RSU, S_RCD, S_CSU, S_CAS, S_PRE} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [2:0]       op;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DW-1:0]    wd_q;
  logic [RCW-1:0]   ref_cnt;
  logic             ref_pend;
  logic [ROW_W-1:0] ref_row;

  logic col_phase, cas_phase, is_ref, we_lo, last, fire, start_ref, capture;

  assign col_phase = (st == S_CSU) || (st == S_CAS);
  assign cas_phase = (st == S_CAS);
  assign is_ref    = (op == OP_REF);
  assign fire      = (ref_cnt == RCW'(REF_PERIOD - 1));
  assign start_ref = (st == S_IDLE) && ref_pend;
  assign capture   = cas_phase && (op == OP_RD || op == OP_RMW) && (cnt == CW'(T_CAS - 1));

  assign req_ready   = (st == S_IDLE) && !ref_pend;
  assign dram_ras_n  = !((st == S_RCD) || col_phase);
  assign dram_cas_n  = !(cas_phase && !is_ref);
  assign dram_we_n   = !we_lo;
  assign dram_dq_oe  = we_lo;
  assign dram_dq_out = we_lo ? wd_q : '0;

  always_comb begin
    case (op)
      OP_LW:   we_lo = cas_phase && (cnt != '0);
      OP_EW:   we_lo = col_phase;
      OP_RMW:  we_lo = cas_phase && (cnt >= CW'(T_CAS));
      default: we_lo = 1'b0;
    endcase
  end

  always_comb begin
    dram_a = '0;
    if ((st == S_RSU) || (st == S_RCD) || (col_phase && is_ref))
      dram_a[ROW_W-1:0] = row_q;
    else if (col_phase)
      dram_a[COL_W-1:0] = col_q;
  end

  always_comb begin
    case (st)
      S_RSU:   last = (cnt == CW'(T_RSU - 1));
      S_RCD:   last = (cnt == CW'(T_RCD - 1));
      S_CSU:   last = (cnt == CW'(T_CSU - 1));
      S_CAS:   last = (op == OP_RMW) ? (cnt == CW'(2 * T_CAS - 1)) : (cnt == CW'(T_CAS - 1));
      S_PRE:   last = (cnt == CW'(T_RP - 1));
      default: last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      op    <= OP_RD;
      row_q <= '0;
      col_q <= '0;
      wd_q  <= '0;
    end else if (st == S_IDLE) begin
      cnt <= '0;
      if (ref_pend) begin
        st    <= S_RSU;
        op    <= OP_REF;
        row_q <= ref_row;
      end else if (req_valid) begin
        st    <= S_RSU;
        op    <= (req_cmd > OP_REF) ? OP_RD : req_cmd;
        row_q <= req_addr[ROW_W-1:0];
        col_q <= req_addr[ROW_W+COL_W-1:ROW_W];
        wd_q  <= req_wdata;
      end
    end else if (last) begin
      cnt <= '0;
      case (st)
        S_RSU:   st <= S_RCD;
        S_RCD:   st <= S_CSU;
        S_CSU:   st <= S_CAS;
        S_CAS:   st <= S_PRE;
        default: st <= S_IDLE;
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      ref_cnt <= fire ? '0 : ref_cnt + 1'b1;
      if (fire)
        ref_pend <= 1'b1;
      else if (start_ref)
        ref_pend <= 1'b0;
      if (start_ref)
        ref_row <= ref_row + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture)
        rsp_data <= dram_dq_in;
    end
  end

  p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_a));

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_we_in_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_ras_n);

  p_ref_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && st != S_IDLE) |-> (dram_cas_n && dram_we_n && !rsp_valid));

  p_ref_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && ref_pend) |=> (st == S_RSU && op == OP_REF));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> !req_ready);

endmodule

// File: tb/dram_seq_test.sv
`timescale 1ns/1ps
module dram_seq_test;
  localparam int ROW_W = 10, COL_W = 10, DW = 4;
  localparam int T_RSU = 1, T_RCD = 2, T_CSU = 1, T_CAS = 3, T_RP = 2;
  localparam int REFP = 40;
  localparam int NROW = 1 << ROW_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_cmd = 0;
  logic [19:0] req_addr = 0;
  logic [3:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [3:0] rsp_data, dram_dq_out;
  logic [9:0] dram_a;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [3:0] dram_dq_in = 0;

  always #2.5 clk = ~clk;

  dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RSU(T_RSU), .T_RCD(T_RCD),
             .T_CSU(T_CSU), .T_CAS(T_CAS), .T_RP(T_RP), .REF_PERIOD(REFP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  function automatic logic [3:0] dflt(input int k);
    return 4'((k ^ (k >> 10) ^ (k >> 4)) & 15);
  endfunction

  // behavioural memory device, sampled between clock edges
  logic [3:0] dmem [int];
  logic [9:0] lat_row = 0, lat_col = 0;
  logic p_ras = 1, p_cas = 1;
  always @(negedge clk) begin
    if (!dram_ras_n && p_ras) lat_row = dram_a;
    if (!dram_cas_n && p_cas) lat_col = dram_a;
    if (!dram_ras_n && !dram_cas_n && !dram_we_n)
      dmem[{lat_col, lat_row}] = dram_dq_out;
    if (!dram_ras_n && !dram_cas_n && dram_we_n)
      dram_dq_in = dmem.exists({lat_col, lat_row}) ? dmem[{lat_col, lat_row}] : dflt({lat_col, lat_row});
    else
      dram_dq_in = 4'h0;
    p_ras = dram_ras_n;
    p_cas = dram_cas_n;
  end

  // reference model
  typedef struct {logic [18:0] pins; string tag; logic [3:0] rd;} ent_t;
  ent_t q[$];
  logic [3:0] shadow [int];
  int tcnt = 0, ptr = 0;
  bit pend = 0;

  function automatic logic [18:0] mk(input logic ras, cas, we, oe, input logic [9:0] a,
                                     input logic [3:0] d, input logic rv);
    return {ras, cas, we, oe, a, d, rv};
  endfunction
  localparam logic [18:0] IDLE = {1'b1, 1'b1, 1'b1, 1'b0, 10'd0, 4'd0, 1'b0};

  task automatic push(input logic [18:0] p, input string t, input logic [3:0] rd);
    ent_t e;
    e.pins = p; e.tag = t; e.rd = rd;
    q.push_back(e);
  endtask

  task automatic push_seq(input int kind, input logic [9:0] row, input logic [9:0] col,
                          input logic [3:0] wd, input logic [3:0] rd, input string t);
    int ncas;
    logic we, cas, rv;
    logic [9:0] a;
    a = (kind == 4) ? row : col;
    for (int i = 0; i < T_RSU; i++) push(mk(1, 1, 1, 0, row, 0, 0), t, rd);
    for (int i = 0; i < T_RCD; i++) push(mk(0, 1, 1, 0, row, 0, 0), t, rd);
    for (int i = 0; i < T_CSU; i++) begin
      we = (kind == 2) ? 1'b0 : 1'b1;
      push(mk(0, 1, we, !we, a, we ? 4'h0 : wd, 0), t, rd);
    end
    ncas = (kind == 3) ? 2 * T_CAS : T_CAS;
    for (int i = 0; i < ncas; i++) begin
      cas = (kind == 4);
      case (kind)
        1: we = (i == 0);
        2: we = 1'b0;
        3: we = (i < T_CAS);
        default: we = 1'b1;
      endcase
      rv = (kind == 3) && (i == T_CAS);
      push(mk(0, cas, we, !we, a, we ? 4'h0 : wd, rv), t, rd);
    end
    for (int i = 0; i < T_RP; i++) push(mk(1, 1, 1, 0, 0, 0, (kind == 0) && (i == 0)), t, rd);
  endtask

  task automatic cycle(input logic v, input logic [2:0] c, input logic [19:0] ad,
                       input logic [3:0] wd, output bit acc);
    logic [18:0] act, ex;
    logic rexp;
    string tag;
    bit start, fire;
    int kind;
    logic [3:0] old;
    req_valid = v; req_cmd = c; req_addr = ad; req_wdata = wd;
    #1;
    if (q.size() > 0) begin ex = q[0].pins; tag = q[0].tag; end
    else begin ex = IDLE; tag = "R12"; end
    rexp = (q.size() == 0) && !pend;
    act = {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, dram_a, dram_dq_out, rsp_valid};
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s cycle %0d pins act=%h exp=%h", tag, cyc, act, ex);
    end else if (req_ready !== rexp) begin
      fails++;
      $display("FAIL %s cycle %0d ready act=%b exp=%b", pend ? "R9" : "R10", cyc, req_ready, rexp);
    end
    if (q.size() > 0 && q[0].pins[0]) begin
      checks++;
      if (rsp_data !== q[0].rd) begin
        fails++;
        $display("FAIL %s cycle %0d rsp_data act=%h exp=%h", tag, cyc, rsp_data, q[0].rd);
      end
    end
    @(posedge clk);
    cyc++;
    acc = 0; start = 0;
    if (q.size() > 0) void'(q.pop_front());
    else if (pend) begin
      push_seq(4, 10'(ptr), 0, 0, 0, "R8");
      ptr = (ptr + 1) % NROW;
      start = 1;
    end else if (v) begin
      acc = 1;
      kind = (c > 4) ? 0 : int'(c);
      old = shadow.exists(int'(ad)) ? shadow[int'(ad)] : dflt(int'(ad));
      if (kind >= 1 && kind <= 3) shadow[int'(ad)] = wd;
      case (kind)
        0: tag = (c > 4) ? "R11" : "R3";
        1: tag = "R4";
        2: tag = "R5";
        3: tag = "R6";
        default: tag = "R7";
      endcase
      push_seq(kind, ad[9:0], ad[19:10], wd, old, tag);
    end
    fire = (tcnt == REFP - 1);
    tcnt = fire ? 0 : tcnt + 1;
    pend = fire || (pend && !start);
    @(negedge clk);
  endtask

  task automatic req(input logic [2:0] c, input logic [19:0] ad, input logic [3:0] wd);
    bit acc;
    acc = 0;
    while (!acc) cycle(1, c, ad, wd, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, acc);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [19:0] pick;
    logic [9:0] r, cl;
    case ($urandom_range(0, 3))
      0: r = 10'h000; 1: r = 10'h3FF; 2: r = 10'h155; default: r = 10'h0A2;
    endcase
    case ($urandom_range(0, 3))
      0: cl = 10'h000; 1: cl = 10'h3FF; 2: cl = 10'h2AA; default: cl = 10'h011;
    endcase
    return {cl, r};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;  // R1 reset state
    if ({dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, dram_a, dram_dq_out, rsp_valid} !== IDLE
        || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset pins act=%h exp=%h ready=%b", {dram_ras_n, dram_cas_n, dram_we_n,
               dram_dq_oe, dram_a, dram_dq_out, rsp_valid}, IDLE, req_ready);
    end
    @(negedge clk);
    rst_n = 1;
    // R2, R5, R3: early write then read at top corner
    req(3'd2, 20'hFFFFF, 4'hA);
    req(3'd0, 20'hFFFFF, 4'h0);
    // R4: late write then read
    req(3'd1, 20'h00401, 4'h5);
    req(3'd0, 20'h00401, 4'h0);
    // R6: read-modify-write twice on one word
    req(3'd3, 20'h12345, 4'hC);
    req(3'd3, 20'h12345, 4'h3);
    req(3'd0, 20'h12345, 4'h0);
    // R7: explicit refresh; R11: spare command codes
    req(3'd4, 20'hABFFF, 4'hF);
    req(3'd6, 20'hFFFFF, 4'h0);
    req(3'd5, 20'h00401, 4'h0);
    req(3'd7, 20'h00000, 4'h0);
    idle(50);
    // R9, R10: back-to-back and random traffic crossing refresh windows
    for (int i = 0; i < 400; i++) begin
      req(3'($urandom_range(0, 7)), pick(), 4'($urandom));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    // R8: long idle stretch, pointer goes past the last row and wraps
    idle((NROW + 8) * REFP);
    req(3'd0, 20'h12345, 4'h0);
    idle(20);
    summary();
  end
endmodule